// File: doc/BRIEF.md
# Port-Mapped Vectored Interrupt Controller

This block is the interrupt front end of a small 16-bit handheld processor. Eight interrupt sources arrive as level pulses; one of them, source 6, is the vertical-blank event from the video timing. The block records a rising edge on an enabled source as a pending status bit. It raises a single request to the processor core and supplies the vector number of the most important pending source. Software sees four byte-wide I/O ports: a vector base, an enable mask, a readable status word and a write-only acknowledge port that clears status bits selectively.

The request follows the processor's own interrupt-enable flag, and a one-cycle inhibit strobe from the core holds it off after instructions that must not be interrupted. Acceptance by the core does not clear a pending bit; the handler must acknowledge it. A model-select input chooses between a monochrome variant and a colour variant of the vector-base register. The two variants keep different base bits on a write and return different values on a read-back.

Top module: `pm_intc`

## Requirements
- R1: After reset the stored base, enable mask and status are all zero, so the enable port reads 0x00, the status port reads 0x00, the base port reads 0x03 in monochrome mode, and irq_req is 0.
- R2: Port decode uses the full 16-bit address: base at 0x00B0, enable at 0x00B2, status at 0x00B4 (read), acknowledge at 0x00B6 (write). A read of any other address, including 0x00B6, returns 0x00, and a write to any other address changes nothing.
- R3: A write to 0x00B6 clears each status bit whose data bit is 1 and leaves the status bits whose data bit is 0 unchanged.
- R4: With model_color = 0, a base write stores data with bits 2:0 cleared, and a base read returns the stored value with bits 1:0 forced to 1.
- R5: With model_color = 1, a base write stores data with only bit 0 cleared, and a base read returns the stored value unchanged.
- R6: Status bit i is set one clock after src_pulse[i] goes from 0 to 1, and only when enable bit i is 1 in that cycle. A source held high sets its bit once, and a rising edge on a disabled source sets nothing.
- R7: When a rising edge on an enabled source and an acknowledge of the same bit occur in the same cycle, the bit ends up set.
- R8: irq_req is 1 exactly when (status & enable) is nonzero, cpu_ie is 1 and inhibit is 0. Status bits latch regardless of cpu_ie, so source 6 (vertical blank) becomes pending while cpu_ie is 0.
- R9: irq_vector equals the stored base plus the index of the highest-numbered bit of (status & enable), modulo 256. It equals the stored base when no bit is pending.
- R10: A status bit is never cleared except by an acknowledge write. It stays set across cycles in which irq_req is 1.
- R11: A write to the status port 0x00B4 has no effect on the status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| model_color | input | 1 | 0 = monochrome base variant, 1 = colour base variant |
| port_addr | input | 16 | I/O port address for reads and writes |
| wr_en | input | 1 | Write strobe for port_addr / wr_data |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data for port_addr |
| src_pulse | input | 8 | Interrupt source levels; bit 6 is vertical blank |
| cpu_ie | input | 1 | Processor interrupt-enable flag |
| inhibit | input | 1 | Core strobe that holds the request off for this boundary |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vector | output | 8 | Vector number presented with the request |

## Verification
The properties assume that the sources, the port strobe and the two core flags are synchronous to clk and stable around the rising edge. They also assume that the acknowledge property only applies in a cycle with no source high, since a simultaneous edge legally re-sets a bit. The bench drives every input at the falling edge and holds it through the next rising edge. Its random mix keeps the source density low enough that edges, holds and acknowledges interleave. Directed steps then place an edge and an acknowledge in the same cycle on purpose.

// File: rtl/pm_intc_pkg.sv
package pm_intc_pkg;

  localparam int unsigned PORT_BASE   = 32'h00B0;
  localparam int unsigned PORT_ENABLE = 32'h00B2;
  localparam int unsigned PORT_STATUS = 32'h00B4;
  localparam int unsigned PORT_ACK    = 32'h00B6;

  localparam int unsigned VBLANK_SRC  = 6;

  typedef enum logic [2:0] {
    SEL_NONE   = 3'd0,
    SEL_BASE   = 3'd1,
    SEL_ENABLE = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_ACK    = 3'd4
  } port_sel_e;

endpackage

// File: rtl/pm_intc_rst_sync.sv
module pm_intc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pm_intc_edge.sv
module pm_intc_edge #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise
);

  logic [N-1:0] lvl_q;
  logic [N-1:0] lvl_d;

  always_comb begin
    lvl_d = lvl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_rise
      assign rise[gi] = lvl[gi] & ~lvl_q[gi];
    end
  endgenerate

endmodule

// File: rtl/pm_intc_regfile.sv
module pm_intc_regfile
  import pm_intc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_color,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic [DW-1:0]     src_rise,
  output logic [DW-1:0]     rd_data,
  output logic [DW-1:0]     base_q,
  output logic [DW-1:0]     enable_q,
  output logic [DW-1:0]     status_q
);

  localparam logic [DW-1:0] MONO_KEEP  = {{(DW-3){1'b1}}, 3'b000};
  localparam logic [DW-1:0] COLOR_KEEP = {{(DW-1){1'b1}}, 1'b0};
  localparam logic [DW-1:0] MONO_FORCE = {{(DW-2){1'b0}}, 2'b11};

  port_sel_e       sel;
  logic            base_ce;
  logic            enable_ce;
  logic            status_ce;
  logic [DW-1:0]   base_d;
  logic [DW-1:0]   enable_d;
  logic [DW-1:0]   status_d;
  logic [DW-1:0]   ack_mask;
  logic [DW-1:0]   set_mask;

  // address decode
  always_comb begin
    if      (port_addr == ADDR_W'(PORT_BASE))   sel = SEL_BASE;
    else if (port_addr == ADDR_W'(PORT_ENABLE)) sel = SEL_ENABLE;
    else if (port_addr == ADDR_W'(PORT_STATUS)) sel = SEL_STATUS;
    else if (port_addr == ADDR_W'(PORT_ACK))    sel = SEL_ACK;
    else                                        sel = SEL_NONE;
  end

  // next state
  always_comb begin
    base_ce   = wr_en && (sel == SEL_BASE);
    enable_ce = wr_en && (sel == SEL_ENABLE);
    base_d    = model_color ? (wr_data & COLOR_KEEP) : (wr_data & MONO_KEEP);
    enable_d  = wr_data;
    ack_mask  = (wr_en && (sel == SEL_ACK)) ? wr_data : '0;
    set_mask  = src_rise & enable_q;
    // a new edge wins over a same-cycle acknowledge
    status_d  = (status_q & ~ack_mask) | set_mask;
    status_ce = (ack_mask != '0) || (set_mask != '0);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_ce) begin
      base_q <= base_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (enable_ce) begin
      enable_q <= enable_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_ce) begin
      status_q <= status_d;
    end
  end

  // read mux
  always_comb begin
    unique case (sel)
      SEL_BASE:   rd_data = model_color ? base_q : (base_q | MONO_FORCE);
      SEL_ENABLE: rd_data = enable_q;
      SEL_STATUS: rd_data = status_q;
      default:    rd_data = '0;
    endcase
  end

endmodule

// File: rtl/pm_intc_prio.sv
module pm_intc_prio #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pending,
  output logic [IDX_W-1:0] win_idx,
  output logic             any
);

  logic [IDX_W-1:0] idx_chain [N+1];

  assign idx_chain[0] = '0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_scan
      // later (higher-numbered) stages override earlier ones
      assign idx_chain[gi+1] = pending[gi] ? IDX_W'(gi) : idx_chain[gi];
    end
  endgenerate

  assign win_idx = idx_chain[N];
  assign any     = |pending;

endmodule

// File: rtl/pm_intc.sv
module pm_intc #(
  parameter int ADDR_W = 16,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              model_color,
  input  logic [ADDR_W-1:0] port_addr,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  input  logic [DW-1:0]     src_pulse,
  input  logic              cpu_ie,
  input  logic              inhibit,
  output logic              irq_req,
  output logic [DW-1:0]     irq_vector
);

  localparam int N_SRC = DW;
  localparam int IDX_W = $clog2(N_SRC);

  logic              rst_sync_n;
  logic [N_SRC-1:0]  src_rise;
  logic [DW-1:0]     base_q;
  logic [DW-1:0]     enable_q;
  logic [DW-1:0]     status_q;
  logic [N_SRC-1:0]  pending;
  logic [IDX_W-1:0]  win_idx;
  logic              any_pending;

  pm_intc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pm_intc_edge #(.N(N_SRC)) u_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lvl   (src_pulse),
    .rise  (src_rise)
  );

  pm_intc_regfile #(.ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .model_color (model_color),
    .port_addr   (port_addr),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .src_rise    (src_rise),
    .rd_data     (rd_data),
    .base_q      (base_q),
    .enable_q    (enable_q),
    .status_q    (status_q)
  );

  assign pending = status_q & enable_q;

  pm_intc_prio #(.N(N_SRC), .IDX_W(IDX_W)) u_prio (
    .pending (pending),
    .win_idx (win_idx),
    .any     (any_pending)
  );

  assign irq_req    = any_pending & cpu_ie & ~inhibit;
  assign irq_vector = base_q + {{(DW-IDX_W){1'b0}}, win_idx};

endmodule

// File: rtl/pm_intc_chk.sv
module pm_intc_chk #(
  parameter int ADDR_W = 16,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              model_color,
  input logic [ADDR_W-1:0] port_addr,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic [DW-1:0]     src_pulse,
  input logic              cpu_ie,
  input logic              inhibit,
  input logic              irq_req,
  input logic [DW-1:0]     irq_vector,
  input logic [DW-1:0]     base_q,
  input logic [DW-1:0]     enable_q,
  input logic [DW-1:0]     status_q
);

  logic [DW-1:0] pend;
  logic [DW-1:0] vec_off;
  logic          wr_ack;
  logic          wr_base;

  assign pend    = status_q & enable_q;
  assign vec_off = irq_vector - base_q;
  assign wr_ack  = wr_en && (port_addr == ADDR_W'(16'h00B6));
  assign wr_base = wr_en && (port_addr == ADDR_W'(16'h00B0));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ack && (src_pulse == '0)) |=> ((status_q & $past(wr_data)) == '0));

  assert_mono_base_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && !model_color) |=> (base_q[2:0] == 3'b000));

  assert_color_base_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_base && model_color) |=> (base_q[0] == 1'b0));

  assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(status_q) & ~$past(enable_q)) == '0));

  assert_req_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cpu_ie && !inhibit && (pend != '0)));

  assert_req_raised_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ie && !inhibit && (pend != '0)) |-> irq_req);

  assert_vector_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ((vec_off < DW) && pend[vec_off[$clog2(DW)-1:0]] &&
                 (((pend >> vec_off) >> 1) == '0)));

  assert_sticky_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ack |=> ((status_q & $past(status_q)) == $past(status_q)));

endmodule

bind pm_intc pm_intc_chk #(.ADDR_W(ADDR_W), .DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .model_color (model_color),
  .port_addr   (port_addr),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .src_pulse   (src_pulse),
  .cpu_ie      (cpu_ie),
  .inhibit     (inhibit),
  .irq_req     (irq_req),
  .irq_vector  (irq_vector),
  .base_q      (base_q),
  .enable_q    (enable_q),
  .status_q    (status_q)
);

// File: tb/pm_intc_test.sv
module pm_intc_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        model_color;
  logic [15:0] port_addr;
  logic        wr_en;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [7:0]  src_pulse;
  logic        cpu_ie;
  logic        inhibit;
  logic        irq_req;
  logic [7:0]  irq_vector;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  // reference state
  logic [7:0] m_base, m_en, m_stat, m_srcq;

  pm_intc uut (
    .clk(clk), .rst_n(rst_n), .model_color(model_color),
    .port_addr(port_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_pulse(src_pulse), .cpu_ie(cpu_ie),
    .inhibit(inhibit), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] f_read(input logic [15:0] a, input logic col);
    case (a)
      16'h00B0: return col ? m_base : (m_base | 8'h03);
      16'h00B2: return m_en;
      16'h00B4: return m_stat;
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] f_vector();
    logic [7:0] p;
    logic [7:0] idx;
    p = m_stat & m_en;
    idx = 0;
    for (int i = 0; i < 8; i++) if (p[i]) idx = 8'(i);
    return m_base + idx;
  endfunction

  function automatic logic f_req(input logic ie, input logic ih);
    return ((m_stat & m_en) != 0) && ie && !ih;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic we, input logic [7:0] d,
                      input logic [7:0] s, input logic ie, input logic ih,
                      input logic col, input string tag);
    logic [7:0] rise, clr, nb, ne, ns;
    @(negedge clk);
    port_addr = a; wr_en = we; wr_data = d; src_pulse = s;
    cpu_ie = ie; inhibit = ih; model_color = col;
    #1;
    chk(tag, "rd_data", rd_data, f_read(a, col));
    chk(tag, "irq_req", {7'b0, irq_req}, {7'b0, f_req(ie, ih)});
    chk(tag, "irq_vector", irq_vector, f_vector());
    rise = s & ~m_srcq;
    clr = 0; nb = m_base; ne = m_en;
    if (we) begin
      if (a == 16'h00B0) nb = col ? (d & 8'hFE) : (d & 8'hF8);
      if (a == 16'h00B2) ne = d;
      if (a == 16'h00B6) clr = d;
    end
    ns = (m_stat & ~clr) | (rise & m_en);
    @(posedge clk);
    m_base = nb; m_en = ne; m_stat = ns; m_srcq = s;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; model_color = 0; port_addr = 0; wr_en = 0; wr_data = 0;
    src_pulse = 0; cpu_ie = 0; inhibit = 0;
    m_base = 0; m_en = 0; m_stat = 0; m_srcq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    step(16'h00B0, 0, 0, 0, 1, 0, 0, "R1");
    step(16'h00B2, 0, 0, 0, 1, 0, 0, "R1");
    step(16'h00B4, 0, 0, 0, 1, 0, 0, "R1");
    // R4 monochrome base
    step(16'h00B0, 1, 8'hFF, 0, 0, 0, 0, "R4");
    step(16'h00B0, 0, 0, 0, 0, 0, 0, "R4");
    // R5 colour base
    step(16'h00B0, 0, 0, 0, 0, 0, 1, "R5");
    step(16'h00B0, 1, 8'hFF, 0, 0, 0, 1, "R5");
    step(16'h00B0, 0, 0, 0, 0, 0, 1, "R5");
    // R2 undecoded reads and writes
    step(16'h00B6, 0, 0, 0, 0, 0, 1, "R2");
    step(16'h12B2, 1, 8'h55, 0, 0, 0, 1, "R2");
    step(16'h00B2, 0, 0, 0, 0, 0, 1, "R2");
    step(16'h00B1, 0, 0, 0, 0, 0, 1, "R2");
    // R6 enable vblank only, edges on bits 6 and 0
    step(16'h00B2, 1, 8'h40, 0, 0, 0, 1, "R6");
    step(16'h00B4, 0, 0, 8'h41, 0, 0, 1, "R6");
    step(16'h00B4, 0, 0, 8'h41, 0, 0, 1, "R6");
    // R8 latched while cpu_ie low, request once raised, inhibit holds off
    step(16'h00B4, 0, 0, 0, 0, 0, 1, "R8");
    step(16'h00B4, 0, 0, 0, 1, 0, 1, "R8");
    step(16'h00B4, 0, 0, 0, 1, 1, 1, "R8");
    // R10 stays pending while requested
    repeat (3) step(16'h00B4, 0, 0, 0, 1, 0, 1, "R10");
    // R9 priority and wrap of base + index
    step(16'h00B2, 1, 8'hFF, 0, 1, 0, 1, "R9");
    step(16'h00B4, 0, 0, 8'h0A, 1, 0, 1, "R9");
    step(16'h00B4, 0, 0, 0, 1, 0, 1, "R9");
    // R3 selective acknowledge
    step(16'h00B6, 1, 8'h40, 0, 1, 0, 1, "R3");
    step(16'h00B4, 0, 0, 0, 1, 0, 1, "R3");
    // R11 status port write ignored
    step(16'h00B4, 1, 8'h00, 0, 1, 0, 1, "R11");
    step(16'h00B4, 0, 0, 0, 1, 0, 1, "R11");
    // R7 edge beats same-cycle acknowledge of bit 0
    step(16'h00B6, 1, 8'h01, 8'h01, 1, 0, 1, "R7");
    step(16'h00B4, 0, 0, 0, 1, 0, 1, "R7");
    step(16'h00B6, 1, 8'hFF, 0, 1, 0, 1, "R3");
    step(16'h00B4, 0, 0, 0, 1, 0, 1, "R3");

    // random mix
    for (int it = 0; it < 3000; it++) begin
      logic [15:0] a;
      logic col;
      case ($urandom % 6)
        0: a = 16'h00B0;
        1: a = 16'h00B2;
        2: a = 16'h00B4;
        3: a = 16'h00B6;
        default: a = 16'($urandom);
      endcase
      col = (($urandom % 20) == 0) ? ~model_color : model_color;
      step(a, ($urandom % 10) < 3, 8'($urandom), 8'($urandom & $urandom),
           ($urandom % 10) < 7, ($urandom % 10) < 2, col, "R9");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule